// File: doc/BRIEF.md
# UART Interrupt Priority Identifier

This block merges the interrupt sources of a UART into a single request line and an identification byte that the CPU reads to learn which source to service. Five sources take part: line-status errors, received data at or above the receive FIFO trigger level, a receive character timeout, transmit holding register empty, and modem-status change. The CPU sets a four-bit enable mask, and the block always reports the highest-ranked enabled source that is pending.

Each source has its own clearing rule, driven by register-access strobes from the surrounding UART. Reads of the line-status, receive-buffer and modem-status registers clear their sources. A write to the holding register clears transmit-empty. A read of the identification byte also clears transmit-empty, but only when that read reported it. The received-data source is a level comparison and needs no clear. The timeout source measures idle time in 16x ticks, using a character time computed from the current frame settings. The FIFO storage, the serialisers and the modem-line sampling sit outside the block.

Top module: `uart_irq_ident`

## Requirements
- R1: While reset is asserted and right after it, `iid` reads 0x01 and `irq` is low.
- R2: Enable bit 0 admits received-data and timeout, bit 1 admits transmit-empty, bit 2 admits line-status, and bit 3 admits modem-status. `irq` is high exactly when an admitted source is pending, and clearing an enable bit drops its source from arbitration in the same cycle.
- R3: `iid[3:0]` gives the winning source. From highest to lowest: line-status 0110, received data 0100, timeout 1100, transmit-empty 0010, modem-status 0000. With nothing pending it reads 0001, so bit 0 is 0 exactly when an interrupt is pending.
- R4: A one-cycle `lsr_err_evt` makes line-status pending from the next cycle. It stays pending until a cycle with `lsr_rd`.
- R5: Received data is pending while `rx_count` is at or above the trigger level. In FIFO mode `rx_trig_sel` 00/01/10/11 gives 1/4/8/14 bytes. Outside FIFO mode the trigger level is 1.
- R6: In FIFO mode with `rx_count` non-zero, the timeout becomes pending once 4 × 16 × B `tick16` pulses have passed with no `rx_push` and no `rbr_rd`. B is 1 + (5 + `word_len`) + `parity_en` + (`stop_two` ? 2 : 1). A push or a receive-buffer read clears the timeout and restarts the count.
- R7: Transmit-empty becomes pending when (`thr_empty` AND enable bit 1) rises. It is cleared by `thr_wr`, or by `iir_rd` in a cycle whose reported code is 0010. An `iir_rd` that reports another source leaves it pending.
- R8: A one-cycle `msr_delta` makes modem-status pending from the next cycle. It stays pending until a cycle with `msr_rd`.
- R9: `iid[7:6]` reads 11 when `fifo_en` is high and 00 otherwise. `iid[5:4]` is always 00.
- R10: If a set event and the clearing access for the same source arrive in the same cycle, the source stays pending.

Top module ports are listed below.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ier_en | input | 4 | Source enable mask |
| fifo_en | input | 1 | FIFO mode on |
| rx_trig_sel | input | 2 | Receive trigger level select |
| word_len | input | 2 | Data bits minus five |
| parity_en | input | 1 | Parity bit present in frame |
| stop_two | input | 1 | Long stop step (counted as two bits) |
| tick16 | input | 1 | 16x bit-rate tick strobe |
| lsr_err_evt | input | 1 | Line error event pulse |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_push | input | 1 | A byte entered the receive FIFO |
| thr_empty | input | 1 | Holding register empty condition |
| msr_delta | input | 1 | Modem line change pulse |
| lsr_rd | input | 1 | Line status register read strobe |
| rbr_rd | input | 1 | Receive buffer read strobe |
| iir_rd | input | 1 | Identification byte read strobe |
| thr_wr | input | 1 | Holding register write strobe |
| msr_rd | input | 1 | Modem status register read strobe |
| irq | output | 1 | Interrupt request |
| iid | output | 8 | Identification byte |

## Verification
Directed patterns stack sources two at a time so that each rank is seen to beat the next one down. They also place a set event and its clearing access in the same cycle, which separates "set wins" from "clear wins". The timeout is probed one tick short of its limit and at the limit, under two frame settings. A wrong character-time formula shows up as an off-by-N edge, not a stuck flag. A long random run then mixes enable masks, occupancy, strobes and transmit-empty toggling against a bench model. This exposes enable-gating and identification-read clearing errors, which only appear when several sources overlap.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [3:0] {
    IID_LINE    = 4'b0110,
    IID_RXDATA  = 4'b0100,
    IID_TIMEOUT = 4'b1100,
    IID_TXEMPTY = 4'b0010,
    IID_MODEM   = 4'b0000,
    IID_NONE    = 4'b0001
  } iid_code_e;

  localparam int unsigned NUM_SRC = 5;

  // Receive trigger threshold in bytes
  function automatic int unsigned trig_level(logic [1:0] sel, logic fifo_on);
    if (!fifo_on) return 1;
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

  // Bits in one frame: start + data + optional parity + stop step
  function automatic int unsigned char_bits(logic [1:0] wl, logic par, logic two_stop);
    return 6 + int'(wl) + int'(par) + (two_stop ? 2 : 1);
  endfunction

endpackage

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk) begin
    if (!rst_n)     q_o <= 1'b0;
    else if (set_i) q_o <= 1'b1;
    else if (clr_i) q_o <= 1'b0;
  end
endmodule

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned IDLE_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fifo_on,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             tick,
  input  logic [1:0]       wl,
  input  logic             par,
  input  logic             two_stop,
  output logic             timeout_o
);
  localparam int unsigned MAX_TICKS = 12 * OVERSAMPLE * IDLE_CHARS;
  localparam int unsigned TW        = $clog2(MAX_TICKS + 1);

  logic [TW-1:0] idle_cnt;
  logic [TW-1:0] limit;
  logic          active;

  assign limit  = TW'(char_bits(wl, par, two_stop) * OVERSAMPLE * IDLE_CHARS);
  assign active = fifo_on && (rx_count != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)                           idle_cnt <= '0;
    else if (!active || rx_push || rx_pop) idle_cnt <= '0;
    else if (tick && idle_cnt < limit)     idle_cnt <= idle_cnt + 1'b1;
  end

  assign timeout_o = active && (idle_cnt >= limit);
endmodule

// File: rtl/uart_irq_arbiter.sv
module uart_irq_arbiter
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,   // index 0 ranks highest
  output iid_code_e          code,
  output logic               any
);
  localparam iid_code_e RANK_CODE [NUM_SRC] =
    '{IID_LINE, IID_RXDATA, IID_TIMEOUT, IID_TXEMPTY, IID_MODEM};

  always_comb begin
    code = IID_NONE;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) code = RANK_CODE[i];
    end
  end

  assign any = |req;
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int unsigned CNT_W      = 5,
  parameter int unsigned OVERSAMPLE = 16,
  parameter int unsigned IDLE_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ier_en,
  input  logic             fifo_en,
  input  logic [1:0]       rx_trig_sel,
  input  logic [1:0]       word_len,
  input  logic             parity_en,
  input  logic             stop_two,
  input  logic             tick16,
  input  logic             lsr_err_evt,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             thr_empty,
  input  logic             msr_delta,
  input  logic             lsr_rd,
  input  logic             rbr_rd,
  input  logic             iir_rd,
  input  logic             thr_wr,
  input  logic             msr_rd,
  output logic             irq,
  output logic [7:0]       iid
);
  localparam int unsigned NUM_STICKY = 3;  // 0 line, 1 tx empty, 2 modem

  logic [NUM_STICKY-1:0] st_set, st_clr, st_q;
  logic ls_pend, thre_pend, ms_pend, to_pend, rda_lvl;
  logic thre_cond, thre_cond_q, thre_rise;
  logic [NUM_SRC-1:0] req;
  iid_code_e rep_code;
  logic any_pend;

  // Transmit-empty rising edge, gated by its enable
  assign thre_cond = thr_empty & ier_en[1];
  always_ff @(posedge clk) begin
    if (!rst_n) thre_cond_q <= 1'b0;
    else        thre_cond_q <= thre_cond;
  end
  assign thre_rise = thre_cond & ~thre_cond_q;

  assign st_set = {msr_delta, thre_rise, lsr_err_evt};
  assign st_clr = {msr_rd,
                   thr_wr | (iir_rd & (rep_code == IID_TXEMPTY)),
                   lsr_rd};

  for (genvar g = 0; g < NUM_STICKY; g++) begin : g_sticky
    uart_irq_latch u_latch (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (st_set[g]),
      .clr_i (st_clr[g]),
      .q_o   (st_q[g])
    );
  end

  assign ls_pend   = st_q[0];
  assign thre_pend = st_q[1];
  assign ms_pend   = st_q[2];

  assign rda_lvl = (rx_count >= CNT_W'(trig_level(rx_trig_sel, fifo_en)));

  uart_irq_timeout #(
    .CNT_W      (CNT_W),
    .OVERSAMPLE (OVERSAMPLE),
    .IDLE_CHARS (IDLE_CHARS)
  ) u_timeout (
    .clk       (clk),
    .rst_n     (rst_n),
    .fifo_on   (fifo_en),
    .rx_count  (rx_count),
    .rx_push   (rx_push),
    .rx_pop    (rbr_rd),
    .tick      (tick16),
    .wl        (word_len),
    .par       (parity_en),
    .two_stop  (stop_two),
    .timeout_o (to_pend)
  );

  assign req = {ms_pend   & ier_en[3],
                thre_pend & ier_en[1],
                to_pend   & ier_en[0],
                rda_lvl   & ier_en[0],
                ls_pend   & ier_en[2]};

  uart_irq_arbiter u_arb (
    .req  (req),
    .code (rep_code),
    .any  (any_pend)
  );

  assign irq = any_pend;
  assign iid = {fifo_en, fifo_en, 2'b00, rep_code};
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] ier_en,
  input logic       lsr_err_evt,
  input logic       lsr_rd,
  input logic       msr_delta,
  input logic       msr_rd,
  input logic       thr_empty,
  input logic       thr_wr,
  input logic       iir_rd,
  input logic       rx_push,
  input logic       rbr_rd,
  input logic [7:0] iid,
  input logic       ls_pend,
  input logic       thre_pend,
  input logic       ms_pend,
  input logic       to_pend
);
  AST_LS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ls_pend && lsr_rd && !lsr_err_evt) |=> !ls_pend); // R4
  AST_LS_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    lsr_err_evt |=> ls_pend); // R10
  AST_MS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ms_pend && msr_rd && !msr_delta) |=> !ms_pend); // R8
  AST_THRE_WRITE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_wr && !thr_empty) |=> !thre_pend); // R7
  AST_THRE_IIR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (thre_pend && iir_rd && !thr_wr && iid[3:0] != 4'b0010) |=> thre_pend); // R7
  AST_LINE_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (ier_en[2] && ls_pend) |-> (iid[3:0] == 4'b0110)); // R3
  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(to_pend) |-> $past(!rx_push && !rbr_rd)); // R6
endmodule

bind uart_irq_ident uart_irq_ident_chk chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .ier_en      (ier_en),
  .lsr_err_evt (lsr_err_evt),
  .lsr_rd      (lsr_rd),
  .msr_delta   (msr_delta),
  .msr_rd      (msr_rd),
  .thr_empty   (thr_empty),
  .thr_wr      (thr_wr),
  .iir_rd      (iir_rd),
  .rx_push     (rx_push),
  .rbr_rd      (rbr_rd),
  .iid         (iid),
  .ls_pend     (ls_pend),
  .thre_pend   (thre_pend),
  .ms_pend     (ms_pend),
  .to_pend     (to_pend)
);

// File: tb/uart_irq_ident_tb_top.sv
module uart_irq_ident_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int CNT_W      = 5;
  localparam int SEED       = 32'h5eed_1357;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] ier_en;
  logic fifo_en;
  logic [1:0] rx_trig_sel, word_len;
  logic parity_en, stop_two, tick16, lsr_err_evt;
  logic [CNT_W-1:0] rx_count;
  logic rx_push, thr_empty, msr_delta;
  logic lsr_rd, rbr_rd, iir_rd, thr_wr, msr_rd;
  logic irq;
  logic [7:0] iid;

  int n_checks = 0;
  int n_fail   = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  uart_irq_ident #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .ier_en(ier_en), .fifo_en(fifo_en),
    .rx_trig_sel(rx_trig_sel), .word_len(word_len), .parity_en(parity_en),
    .stop_two(stop_two), .tick16(tick16), .lsr_err_evt(lsr_err_evt),
    .rx_count(rx_count), .rx_push(rx_push), .thr_empty(thr_empty),
    .msr_delta(msr_delta), .lsr_rd(lsr_rd), .rbr_rd(rbr_rd),
    .iir_rd(iir_rd), .thr_wr(thr_wr), .msr_rd(msr_rd),
    .irq(irq), .iid(iid)
  );

  // ---------------- bench reference functions ----------------
  function automatic int b_trig(logic [1:0] sel, logic fifo);
    int lv [4] = '{1, 4, 8, 14};
    return fifo ? lv[sel] : 1;
  endfunction

  function automatic int b_idle_ticks(logic [1:0] wl, logic par, logic st2);
    int bits;
    bits = 1 + 5 + wl + (par ? 1 : 0) + (st2 ? 2 : 1);
    return 64 * bits;
  endfunction

  function automatic logic [3:0] b_code(logic [3:0] en, logic ls, logic rda,
                                        logic to, logic te, logic ms);
    if (en[2] && ls)  return 4'b0110;
    if (en[0] && rda) return 4'b0100;
    if (en[0] && to)  return 4'b1100;
    if (en[1] && te)  return 4'b0010;
    if (en[3] && ms)  return 4'b0000;
    return 4'b0001;
  endfunction

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic idle_inputs();
    ier_en = 4'h0; fifo_en = 1'b0; rx_trig_sel = 2'b00; word_len = 2'b00;
    parity_en = 1'b0; stop_two = 1'b0; tick16 = 1'b0; lsr_err_evt = 1'b0;
    rx_count = '0; rx_push = 1'b0; thr_empty = 1'b0; msr_delta = 1'b0;
    lsr_rd = 1'b0; rbr_rd = 1'b0; iir_rd = 1'b0; thr_wr = 1'b0; msr_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    #1;
    chk("R1 iid in reset", iid, 8'h01);
    chk("R1 irq in reset", {7'd0, irq}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1 iid after reset", iid, 8'h01);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  // ---------------- model state for random phase ----------------
  logic m_ls, m_te, m_ms, m_tecond_q;
  int   m_idle;
  logic [3:0] m_last_code;

  initial begin
    int lim;
    int unused_seed;
    unused_seed = $urandom(SEED);
    rst_n = 1'b0;
    idle_inputs();
    do_reset();

    // R9: FIFO mode bits with nothing pending
    fifo_en = 1'b1; #1;
    chk("R9 fifo bits idle", iid, 8'hC1);

    // R2 / R4: line error while disabled is hidden, then shown, then hidden
    @(negedge clk); lsr_err_evt = 1'b1;
    @(negedge clk); lsr_err_evt = 1'b0; #1;
    chk("R2 disabled source hidden", iid, 8'hC1);
    chk("R2 irq low when disabled", {7'd0, irq}, 8'h00);
    ier_en = 4'b0100; #1;
    chk("R4 line status reported", iid, 8'hC6);
    chk("R2 irq high when enabled", {7'd0, irq}, 8'h01);
    ier_en = 4'b0000; #1;
    chk("R2 disable drops at once", iid, 8'hC1);

    // R5: trigger level 4
    ier_en = 4'b0101; rx_trig_sel = 2'b01; rx_count = 5'd3; lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0; #1;
    chk("R4 lsr read clears", iid, 8'hC1);
    rx_count = 5'd4; #1;
    chk("R5 at trigger 4", iid, 8'hC4);
    rx_trig_sel = 2'b11; #1;
    chk("R5 below trigger 14", iid, 8'hC1);
    rx_count = 5'd14; #1;
    chk("R5 at trigger 14", iid, 8'hC4);
    fifo_en = 1'b0; rx_count = 5'd1; #1;
    chk("R5 non-fifo trigger 1", iid, 8'h04);

    // R3 / R10: line beats data; set and clear together keeps it
    @(negedge clk); lsr_err_evt = 1'b1;
    @(negedge clk); lsr_err_evt = 1'b1; lsr_rd = 1'b1;
    @(negedge clk); lsr_err_evt = 1'b0; lsr_rd = 1'b0; #1;
    chk("R10 line set wins over read", iid, 8'h06);
    chk("R3 line above data", iid, 8'h06);
    lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0; #1;
    chk("R3 data after line cleared", iid, 8'h04);
    rx_count = '0;

    // R6: timeout at 5n1 -> 448 ticks, then 8 data parity long stop -> 768
    for (int cfg = 0; cfg < 2; cfg++) begin
      @(negedge clk);
      fifo_en = 1'b1; ier_en = 4'b0001; rx_trig_sel = 2'b11; rx_count = 5'd2;
      word_len = cfg ? 2'b11 : 2'b00; parity_en = cfg[0]; stop_two = cfg[0];
      tick16 = 1'b1; rx_push = 1'b1;
      lim = b_idle_ticks(word_len, parity_en, stop_two);
      @(negedge clk); rx_push = 1'b0;
      repeat (lim - 1) @(negedge clk);
      #1 chk("R6 one tick before timeout", iid, 8'hC1);
      @(negedge clk); #1;
      chk("R6 timeout at limit", iid, 8'hCC);
      rbr_rd = 1'b1;
      @(negedge clk); rbr_rd = 1'b0; #1;
      chk("R6 buffer read clears timeout", iid, 8'hC1);
    end
    tick16 = 1'b0; rx_count = '0;

    // R7: transmit empty and its two clears
    ier_en = 4'b0010;
    @(negedge clk); thr_empty = 1'b1;
    @(negedge clk); #1;
    chk("R7 tx empty reported", iid, 8'hC2);
    iir_rd = 1'b1;
    @(negedge clk); iir_rd = 1'b0; #1;
    chk("R7 iir read of tx empty clears", iid, 8'hC1);
    thr_empty = 1'b0;
    @(negedge clk); thr_empty = 1'b1; ier_en = 4'b0110; lsr_err_evt = 1'b1;
    @(negedge clk); lsr_err_evt = 1'b0; #1;
    chk("R3 line above tx empty", iid, 8'hC6);
    iir_rd = 1'b1;
    @(negedge clk); iir_rd = 1'b0; lsr_rd = 1'b1;
    @(negedge clk); lsr_rd = 1'b0; #1;
    chk("R7 iir read of other source keeps tx empty", iid, 8'hC2);
    thr_wr = 1'b1;
    @(negedge clk); thr_wr = 1'b0; #1;
    chk("R7 holding write clears", iid, 8'hC1);

    // R8 / R10: modem status
    ier_en = 4'b1000;
    @(negedge clk); msr_delta = 1'b1;
    @(negedge clk); msr_delta = 1'b0; #1;
    chk("R8 modem reported", iid, 8'hC0);
    chk("R8 irq high", {7'd0, irq}, 8'h01);
    msr_delta = 1'b1; msr_rd = 1'b1;
    @(negedge clk); msr_delta = 1'b0; #1;
    chk("R10 modem set wins over read", iid, 8'hC0);
    @(negedge clk); msr_rd = 1'b0; #1;
    chk("R8 modem read clears", iid, 8'hC1);

    // ---------------- random phase against model ----------------
    do_reset();
    m_ls = 0; m_te = 0; m_ms = 0; m_tecond_q = 0; m_idle = 0; m_last_code = 4'b0001;
    tick16 = 1'b1;
    for (int cyc = 0; cyc < 6000; cyc++) begin
      logic act, rda, te_cond;
      @(negedge clk);
      // effect of the inputs held during the cycle just ended
      te_cond = thr_empty && ier_en[1];
      if (te_cond && !m_tecond_q) m_te = 1;
      else if (thr_wr || (iir_rd && m_last_code == 4'b0010)) m_te = 0;
      m_tecond_q = te_cond;
      if (lsr_err_evt) m_ls = 1; else if (lsr_rd) m_ls = 0;
      if (msr_delta) m_ms = 1; else if (msr_rd) m_ms = 0;
      act = fifo_en && rx_count != 0;
      if (!act || rx_push || rbr_rd) m_idle = 0;
      else if (tick16 && m_idle < b_idle_ticks(word_len, parity_en, stop_two)) m_idle++;
      // new inputs
      if (cyc % 40 == 0) ier_en = 4'($urandom_range(0, 15));
      if (cyc % 500 == 0) fifo_en = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 30) == 0) rx_trig_sel = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 15) == 0) rx_count = CNT_W'($urandom_range(0, 16));
      rx_push     = ($urandom_range(0, 700) == 0);
      rbr_rd      = ($urandom_range(0, 700) == 0);
      lsr_err_evt = ($urandom_range(0, 25) == 0);
      lsr_rd      = ($urandom_range(0, 12) == 0);
      msr_delta   = ($urandom_range(0, 25) == 0);
      msr_rd      = ($urandom_range(0, 12) == 0);
      iir_rd      = ($urandom_range(0, 6) == 0);
      thr_wr      = ($urandom_range(0, 14) == 0);
      if ($urandom_range(0, 10) == 0) thr_empty = ~thr_empty;
      #1;
      act = fifo_en && rx_count != 0;
      rda = (int'(rx_count) >= b_trig(rx_trig_sel, fifo_en));
      m_last_code = b_code(ier_en, m_ls, rda,
                           act && m_idle >= b_idle_ticks(word_len, parity_en, stop_two),
                           m_te, m_ms);
      chk("R2 R3 random iid", iid, {{2{fifo_en}}, 2'b00, m_last_code});
      chk("R2 random irq", {7'd0, irq}, {7'd0, ~m_last_code[0]});
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule